// File: doc/BRIEF.md
# Masked IP Route Lookup Table

This block is the forwarding table of a small four-port IP switch. It holds up to 25 routes. Each route has a network address, a subnet mask, a 4-bit output port bitmap and a valid flag. The host processor fills and edits the table at run time through a simple write port. Writing a route with its valid flag cleared removes it.

The datapath presents a 32-bit destination address with a one-cycle request strobe. A fixed number of cycles later the block raises a one-cycle completion pulse, together with a hit flag and the port bitmap to forward on. A bitmap with several bits set sends the datagram to several ports, which is how multicast is handled.

When several routes match, the one with the longest mask wins. When no route matches, the datagram goes to the processor-attached port, unless the fallback control input is low. A build parameter selects the search engine: either one entry per cycle (sequential), or all entries compared in a single cycle (parallel).

The controller has three states:
- `ST_IDLE` waits for a request. On `lk_valid` it moves to `ST_SCAN` and captures the address and the fallback control.
- `ST_SCAN` visits the table. It stays for 25 cycles in sequential mode and 1 cycle in parallel mode, then moves to `ST_DONE`.
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `rt_lookup`

## Requirements
- R1: After reset, `res_done`, `res_hit` and `res_ports` are all low, and every table entry is invalid, so any lookup misses.
- R2: An entry matches when its valid flag is set and (lookup address AND entry mask) equals the stored entry address. An entry whose stored address has bits set outside its mask therefore never matches.
- R3: Writing an entry with `wr_valid`=0 removes it, and it no longer matches any address.
- R4: Among matching entries, the one whose mask has the most 1 bits wins; on equal counts the lower index wins. A route with an all-zero mask matches every address and loses to any longer match.
- R5: On a hit, `res_ports` equals the winning entry's 4-bit bitmap exactly (bit k = output port k), including bitmaps with several bits set.
- R6: On a miss, `res_hit`=0. `res_ports` is the processor port's one-hot code (1 << CPU_PORT, 4'b1000 by default) if `fallback_en` was high in the request cycle, else 4'b0000.
- R7: `res_done` is a single-cycle pulse. It is high exactly LATENCY cycles after the request cycle, where LATENCY is NUM_ENTRIES+1 (26) in sequential mode and 2 in parallel mode. Outputs are zero whenever `res_done` is low.
- R8: A table write that arrives while the search is in progress is held back. It does not alter that lookup's result and is visible to the next lookup.
- R9: All 25 entries (indices 0 to 24) are usable, including index 24.
- R10: A write accepted outside the search, including in the same cycle as a request, is seen by that request's lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fallback_en | input | 1 | Send misses to the processor port |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 5 | Entry index to write |
| wr_valid | input | 1 | Valid flag for the written entry |
| wr_addr | input | 32 | Network address of the entry |
| wr_mask | input | 32 | Subnet mask of the entry |
| wr_ports | input | 4 | Output port bitmap of the entry |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Destination address to look up |
| res_done | output | 1 | Result pulse |
| res_hit | output | 1 | A route matched |
| res_ports | output | 4 | Output port bitmap |

## Verification
The checker assumes two things about the inputs:
- Requests are raised only while no lookup is outstanding.
- At most one table write arrives between a request and its completion pulse, since the hold-back buffer is one entry deep.

The bench respects both rules. Each lookup is issued only after the previous pulse has been seen. At most one write is placed inside a lookup window, in the same cycle as the request or in the first search cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int IP_W   = 32;
    localparam int PORT_W = 4;
    localparam int LEN_W  = $clog2(IP_W + 1);

    typedef logic [IP_W-1:0]   ip_t;
    typedef logic [PORT_W-1:0] pmap_t;
    typedef logic [LEN_W-1:0]  plen_t;

    typedef struct packed {
        logic  valid;
        ip_t   addr;
        ip_t   mask;
        pmap_t ports;
        plen_t plen;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DONE
    } state_t;

    function automatic plen_t mask_len(ip_t m);
        return plen_t'($countones(m));
    endfunction
endpackage

// File: rtl/rt_table.sv
module rt_table
    import rt_pkg::*;
#(
    parameter int NUM_ENTRIES = 25,
    parameter int IDX_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  ip_t              wr_addr,
    input  ip_t              wr_mask,
    input  pmap_t            wr_ports,
    output entry_t           tbl [NUM_ENTRIES]
);
    entry_t           new_e;
    entry_t           pend_e;
    logic             pend_v;
    logic [IDX_W-1:0] pend_idx;

    always_comb begin
        new_e.valid = wr_valid;
        new_e.addr  = wr_addr;
        new_e.mask  = wr_mask;
        new_e.ports = wr_ports;
        new_e.plen  = mask_len(wr_mask);
    end

    // While a search runs, a write is parked in a one-entry buffer.
    // Outside the search, a parked write drains first and the new one takes its place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tbl[i] <= '0;
            end
            pend_v   <= 1'b0;
            pend_e   <= '0;
            pend_idx <= '0;
        end else if (hold) begin
            if (wr_en) begin
                pend_v   <= 1'b1;
                pend_e   <= new_e;
                pend_idx <= wr_idx;
            end
        end else if (pend_v) begin
            if (int'(pend_idx) < NUM_ENTRIES) begin
                tbl[pend_idx] <= pend_e;
            end
            pend_v   <= wr_en;
            pend_e   <= new_e;
            pend_idx <= wr_idx;
        end else if (wr_en) begin
            if (int'(wr_idx) < NUM_ENTRIES) begin
                tbl[wr_idx] <= new_e;
            end
        end
    end
endmodule

// File: rtl/rt_match.sv
module rt_match
    import rt_pkg::*;
#(
    parameter int NUM_ENTRIES = 25
) (
    input  ip_t                    key,
    input  logic [NUM_ENTRIES-1:0] e_valid,
    input  ip_t                    e_addr [NUM_ENTRIES],
    input  ip_t                    e_mask [NUM_ENTRIES],
    output logic [NUM_ENTRIES-1:0] hit_vec
);
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = e_valid[g] && ((key & e_mask[g]) == e_addr[g]);
    end
endmodule

// File: rtl/rt_pick.sv
module rt_pick
    import rt_pkg::*;
#(
    parameter int NUM_ENTRIES = 25,
    parameter int IDX_W       = 5,
    parameter bit PARALLEL    = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   step,
    input  logic [IDX_W-1:0]       scan_idx,
    input  logic [NUM_ENTRIES-1:0] hit_vec,
    input  plen_t                  e_len   [NUM_ENTRIES],
    input  pmap_t                  e_ports [NUM_ENTRIES],
    output logic                   best_hit,
    output pmap_t                  best_ports
);
    plen_t best_len;

    if (PARALLEL) begin : g_par
        logic  c_hit;
        plen_t c_len;
        pmap_t c_ports;

        // Ascending walk with a strict compare: equal lengths keep the lower index.
        always_comb begin
            c_hit   = 1'b0;
            c_len   = '0;
            c_ports = '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (hit_vec[i] && (!c_hit || e_len[i] > c_len)) begin
                    c_hit   = 1'b1;
                    c_len   = e_len[i];
                    c_ports = e_ports[i];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n || start) begin
                best_hit   <= 1'b0;
                best_len   <= '0;
                best_ports <= '0;
            end else if (step) begin
                best_hit   <= c_hit;
                best_len   <= c_len;
                best_ports <= c_ports;
            end
        end
    end else begin : g_seq
        logic take;

        assign take = hit_vec[scan_idx] && (!best_hit || e_len[scan_idx] > best_len);

        always_ff @(posedge clk) begin
            if (!rst_n || start) begin
                best_hit   <= 1'b0;
                best_len   <= '0;
                best_ports <= '0;
            end else if (step && take) begin
                best_hit   <= 1'b1;
                best_len   <= e_len[scan_idx];
                best_ports <= e_ports[scan_idx];
            end
        end
    end
endmodule

// File: rtl/rt_lookup.sv
module rt_lookup
    import rt_pkg::*;
#(
    parameter  int NUM_ENTRIES = 25,
    parameter  bit PARALLEL    = 1'b0,
    parameter  int CPU_PORT    = 3,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fallback_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [31:0]      wr_addr,
    input  logic [31:0]      wr_mask,
    input  logic [3:0]       wr_ports,
    input  logic             lk_valid,
    input  logic [31:0]      lk_addr,
    output logic             res_done,
    output logic             res_hit,
    output logic [3:0]       res_ports
);
    localparam int    SCAN_CYCLES = PARALLEL ? 1 : NUM_ENTRIES;
    localparam int    LATENCY     = SCAN_CYCLES + 1;
    localparam pmap_t CPU_MASK    = pmap_t'(1) << CPU_PORT;

    state_t           state, nxt;
    ip_t              key_q;
    logic             fb_q;
    logic [IDX_W-1:0] scan_idx;
    logic             last_step;
    logic             start;

    entry_t                 tbl     [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] e_valid;
    ip_t                    e_addr  [NUM_ENTRIES];
    ip_t                    e_mask  [NUM_ENTRIES];
    plen_t                  e_len   [NUM_ENTRIES];
    pmap_t                  e_ports [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic                   best_hit;
    pmap_t                  best_ports;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_fields
        assign e_valid[g] = tbl[g].valid;
        assign e_addr[g]  = tbl[g].addr;
        assign e_mask[g]  = tbl[g].mask;
        assign e_len[g]   = tbl[g].plen;
        assign e_ports[g] = tbl[g].ports;
    end

    rt_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (state == ST_SCAN),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_mask  (wr_mask),
        .wr_ports (wr_ports),
        .tbl      (tbl)
    );

    rt_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .key     (key_q),
        .e_valid (e_valid),
        .e_addr  (e_addr),
        .e_mask  (e_mask),
        .hit_vec (hit_vec)
    );

    rt_pick #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .PARALLEL(PARALLEL)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step       (state == ST_SCAN),
        .scan_idx   (scan_idx),
        .hit_vec    (hit_vec),
        .e_len      (e_len),
        .e_ports    (e_ports),
        .best_hit   (best_hit),
        .best_ports (best_ports)
    );

    assign start     = (state == ST_IDLE) && lk_valid;
    assign last_step = PARALLEL || (scan_idx == IDX_W'(NUM_ENTRIES - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (lk_valid)  nxt = ST_SCAN;
            ST_SCAN: if (last_step) nxt = ST_DONE;
            ST_DONE:                nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // Request capture and scan pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= '0;
            fb_q     <= 1'b0;
            scan_idx <= '0;
        end else if (start) begin
            key_q    <= lk_addr;
            fb_q     <= fallback_en;
            scan_idx <= '0;
        end else if (state == ST_SCAN && !last_step) begin
            scan_idx <= scan_idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        res_done  = 1'b0;
        res_hit   = 1'b0;
        res_ports = '0;
        unique case (state)
            ST_DONE: begin
                res_done  = 1'b1;
                res_hit   = best_hit;
                res_ports = best_hit ? best_ports : (fb_q ? CPU_MASK : pmap_t'(0));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rt_lookup_chk.sv
module rt_lookup_chk #(
    parameter int LATENCY  = 26,
    parameter int CPU_PORT = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic       fallback_en,
    input logic       wr_en,
    input logic       res_done,
    input logic       res_hit,
    input logic [3:0] res_ports
);
    localparam int         CW  = $clog2(LATENCY + 2) + 1;
    localparam logic [3:0] CPU = 4'(1) << CPU_PORT;

    logic          busy;
    logic          fb_q;
    logic [CW-1:0] cnt;
    logic [1:0]    wr_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            fb_q    <= 1'b0;
            cnt     <= '0;
            wr_seen <= '0;
        end else if (!busy && lk_valid) begin
            busy    <= 1'b1;
            fb_q    <= fallback_en;
            cnt     <= CW'(1);
            wr_seen <= 2'(wr_en);
        end else if (busy) begin
            if (res_done) begin
                busy <= 1'b0;
            end
            cnt <= cnt + 1'b1;
            if (wr_en && wr_seen != 2'd3) begin
                wr_seen <= wr_seen + 1'b1;
            end
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);

    assert_done_on_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> (busy && cnt == CW'(LATENCY)));

    assert_done_due_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CW'(LATENCY)) |-> res_done);

    assert_quiet_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> (!res_hit && res_ports == 4'b0000));

    assert_miss_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !res_hit) |-> (res_ports == (fb_q ? CPU : 4'b0000)));

    assert_single_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |-> (wr_seen == 2'd0));
endmodule

bind rt_lookup rt_lookup_chk #(.LATENCY(LATENCY), .CPU_PORT(CPU_PORT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .fallback_en (fallback_en),
    .wr_en       (wr_en),
    .res_done    (res_done),
    .res_hit     (res_hit),
    .res_ports   (res_ports)
);

// File: tb/sim_rt_lookup.sv
module sim_rt_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 25;
    localparam int LAT0 = N + 1;
    localparam int LAT1 = 2;
    localparam int NV   = 8;

    // {address, expected hit, expected ports}
    localparam logic [36:0] VEC [NV] = '{
        {32'h0A000005, 1'b1, 4'b0001},
        {32'h0A010305, 1'b1, 4'b0010},
        {32'h0A010203, 1'b1, 4'b0100},
        {32'hC0A80101, 1'b1, 4'b0011},
        {32'hAC100505, 1'b1, 4'b0100},
        {32'hAC100504, 1'b0, 4'b1000},
        {32'h0A020001, 1'b1, 4'b0001},
        {32'h0B000000, 1'b0, 4'b1000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fallback_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_mask = '0;
    logic [3:0]  wr_ports = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        d0, h0, d1, h1;
    logic [3:0]  p0, p1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rt_lookup #(.NUM_ENTRIES(N), .PARALLEL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .fallback_en(fallback_en), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .wr_ports(wr_ports), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_done(d0), .res_hit(h0), .res_ports(p0)
    );

    rt_lookup #(.NUM_ENTRIES(N), .PARALLEL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .fallback_en(fallback_en), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .wr_ports(wr_ports), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_done(d1), .res_hit(h1), .res_ports(p1)
    );

    task automatic check(bit ok, string tag, string eng, logic ah, logic [3:0] ap,
                         logic eh, logic [3:0] ep, bit tim);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s]: hit=%0b ports=%b R7-timing-ok=%0b, expected hit=%0b ports=%b",
                     tag, eng, ah, ap, tim, eh, ep);
        end
    endtask

    task automatic set_wr(logic [4:0] i, logic v, logic [31:0] a, logic [31:0] m, logic [3:0] p);
        wr_idx = i; wr_valid = v; wr_addr = a; wr_mask = m; wr_ports = p;
    endtask

    task automatic put(logic [4:0] i, logic v, logic [31:0] a, logic [31:0] m, logic [3:0] p);
        @(negedge clk);
        set_wr(i, v, a, m, p);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // wr_at: 0 none, 1 write in the request cycle, 2 write in the first search cycle
    task automatic lookup(logic [31:0] a, logic eh, logic [3:0] ep, int wr_at, string tag);
        bit t0 = 1'b1, t1 = 1'b1;
        logic rh0 = 1'bx, rh1 = 1'bx;
        logic [3:0] rp0 = 'x, rp1 = 'x;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        wr_en    = (wr_at == 1);
        for (int k = 1; k <= LAT0; k++) begin
            @(negedge clk);
            if (k == 1) begin
                lk_valid = 1'b0;
                wr_en    = (wr_at == 2);
            end
            if (k == 2) wr_en = 1'b0;
            if (d0 !== (k == LAT0)) t0 = 1'b0;
            if (d1 !== (k == LAT1)) t1 = 1'b0;
            if (k == LAT0) begin rh0 = h0; rp0 = p0; end
            if (k == LAT1) begin rh1 = h1; rp1 = p1; end
        end
        check(t0 && rh0 === eh && rp0 === ep, tag, "sequential", rh0, rp0, eh, ep, t0);
        check(t1 && rh1 === eh && rp1 === ep, tag, "parallel", rh1, rp1, eh, ep, t1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(d0 === 1'b0 && h0 === 1'b0 && p0 === 4'b0000, "R1 reset outputs", "sequential",
              h0, p0, 1'b0, 4'b0000, d0 === 1'b0);
        check(d1 === 1'b0 && h1 === 1'b0 && p1 === 4'b0000, "R1 reset outputs", "parallel",
              h1, p1, 1'b0, 4'b0000, d1 === 1'b0);
        lookup(32'h0A000005, 1'b0, 4'b1000, 0, "R1 empty table misses");

        put(5'd0,  1'b1, 32'h0A000000, 32'hFF000000, 4'b0001);
        put(5'd1,  1'b1, 32'h0A010000, 32'hFFFF0000, 4'b0010);
        put(5'd2,  1'b1, 32'h0A010200, 32'hFFFFFF00, 4'b0100);
        put(5'd3,  1'b1, 32'hC0A80000, 32'hFFFF0000, 4'b0011);
        put(5'd4,  1'b1, 32'h0A010000, 32'hFFFF0000, 4'b1000);
        put(5'd6,  1'b1, 32'h0A020001, 32'hFFFF0000, 4'b1000);
        put(5'd24, 1'b1, 32'hAC100505, 32'hFFFFFFFF, 4'b0100);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i][36:5], VEC[i][4], VEC[i][3:0], 0,
                   $sformatf("vector %0d R2/R4/R5/R6/R9", i));
        end

        fallback_en = 1'b0;
        lookup(32'h0B000000, 1'b0, 4'b0000, 0, "R6 fallback disabled");
        fallback_en = 1'b1;

        put(5'd2, 1'b0, 32'h0A010200, 32'hFFFFFF00, 4'b0100);
        lookup(32'h0A010203, 1'b1, 4'b0010, 0, "R3 removed entry ignored");

        set_wr(5'd2, 1'b1, 32'h0A010200, 32'hFFFFFF00, 4'b0100);
        lookup(32'h0A010203, 1'b1, 4'b0010, 2, "R8 write during search held back");
        lookup(32'h0A010203, 1'b1, 4'b0100, 0, "R8 held write visible next");

        set_wr(5'd7, 1'b1, 32'h0C000000, 32'hFF000000, 4'b0101);
        lookup(32'h0C010101, 1'b1, 4'b0101, 1, "R10 write with request seen");

        put(5'd5, 1'b1, 32'h00000000, 32'h00000000, 4'b0110);
        lookup(32'h0B000000, 1'b1, 4'b0110, 0, "R4 zero mask catches all");
        lookup(32'h0A000005, 1'b1, 4'b0001, 0, "R4 longer mask beats zero mask");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule